// File: doc/BRIEF.md
# ADC Sample and Conversion Sequencer

This block is the digital controller that sits in front of a successive-approximation converter. One control register sets everything: an enable, an auto-sample switch, a sample bit, a done flag, a result format and a trigger choice. Software and hardware both own the sample and done bits. Software or hardware opens a sampling phase. The selected trigger closes it: a software write, a rising edge on an external pin, a timer period match, a measurement-unit event, or an internal cycle counter. When sampling closes, the block sends a one-cycle start pulse to the converter.

When the converter reports completion, the block captures the 10-bit result and sets the done flag. It then presents the result on a 32-bit output word in one of eight layouts: unsigned or signed, integer or left-justified fraction, 16-bit or 32-bit. Signed layouts treat the raw code as offset binary. With auto-sample on, sampling restarts by itself after every conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0, `dout` is 0 and `conv_start` is low. The field layout is: bit 0 enable, bit 1 auto-sample, bit 2 sample, bit 3 done, bits 6:4 format, bits 10:8 trigger select. Every other bit reads 0.
- R2: Trigger select 000 is a software write, 001 is a rising edge of `trig_pin`, 010 is a `trig_tmr` pulse and 011 is a `trig_meas` pulse. 111 is the internal counter. When the selected trigger fires during sampling, `conv_start` is high for one cycle on the next cycle and the sample bit is cleared.
- R3: Writing 1 to the sample bit starts sampling if the block was enabled and no conversion is pending. With trigger select 000, a write with the sample bit at 0 during sampling ends sampling and starts a conversion.
- R4: With trigger select 111, the sample bit stays high for exactly SAMP_CYCLES cycles (default 3), and then the conversion starts.
- R5: A `conv_valid` pulse during a conversion sets done and captures `conv_result`. Done is cleared when the next conversion starts.
- R6: Writing 0 to done clears it, and writing 1 to done has no effect. Clearing done during a conversion does not disturb that conversion. If a clear and a completion land in the same cycle, done ends up set.
- R7: The format field sets `dout`, where s is the result with its MSB inverted. 000 and 100 give the unsigned value in bits 9:0. 001 gives s sign-extended to 16 bits, and 101 gives s sign-extended to 32 bits. 010 gives the unsigned value in bits 15:6 and 011 gives s there. 110 gives the unsigned value in bits 31:22 and 111 gives s there.
- R8: Triggers are ignored while the enable is 0, while a conversion is pending or `conv_busy` is high, or while trigger select is reserved (100 to 110). In those cases the sample bit is kept and no start is issued.
- R9: With auto-sample set, the sample bit rises on the cycle after done is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read data |
| trig_pin | input | 1 | External pin trigger, rising edge active |
| trig_tmr | input | 1 | Timer period match pulse |
| trig_meas | input | 1 | Measurement-unit event pulse |
| conv_start | output | 1 | One-cycle converter start pulse |
| conv_busy | input | 1 | Converter busy |
| conv_valid | input | 1 | Converter completion pulse |
| conv_result | input | 10 | Converter raw result |
| dout | output | 32 | Formatted result word |

## Verification
Two functions can fall in the same cycle: the software write that clears done and the converter completion that sets it. The bench raises `conv_valid` and drives a done-clearing register write on the same clock edge. It then expects done to read 1 and `dout` to carry the new result. A second collision is a write of 1 to the sample bit while a conversion is pending. The bench expects the sample bit to stay 0 and no further start pulse to appear.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int BIT_EN   = 0;
    localparam int BIT_ASAM = 1;
    localparam int BIT_SAMP = 2;
    localparam int BIT_DONE = 3;
    localparam int FMT_LSB  = 4;
    localparam int TSEL_LSB = 8;

    typedef enum logic [2:0] {
        TRG_SW   = 3'b000,
        TRG_PIN  = 3'b001,
        TRG_TMR  = 3'b010,
        TRG_MEAS = 3'b011,
        TRG_AUTO = 3'b111
    } trig_sel_e;

    function automatic logic tsel_reserved(input logic [2:0] t);
        return (t == 3'b100) || (t == 3'b101) || (t == 3'b110);
    endfunction
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
    import adc_seq_pkg::*;
#(
    parameter int SAMP_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] tsel,
    input  logic       arm,
    input  logic       sw_end,
    input  logic       pin,
    input  logic       tmr,
    input  logic       meas,
    output logic       fire
);
    localparam int CNT_W = $clog2(SAMP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMP_CYCLES - 1);

    typedef struct packed {
        logic             pin;
        logic [CNT_W-1:0] cnt;
    } trig_state_t;

    trig_state_t q, d;
    logic pin_rise, cnt_hit, raw;

    always_comb begin
        d        = q;
        d.pin    = pin;
        pin_rise = pin & ~q.pin;
        cnt_hit  = (q.cnt == CNT_LAST);
        case (tsel)
            TRG_SW:   raw = sw_end;
            TRG_PIN:  raw = pin_rise;
            TRG_TMR:  raw = tmr;
            TRG_MEAS: raw = meas;
            TRG_AUTO: raw = cnt_hit;
            default:  raw = 1'b0;
        endcase
        fire = arm & raw;
        if (arm && tsel == TRG_AUTO) begin
            d.cnt = cnt_hit ? '0 : q.cnt + 1'b1;
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_LAST);
    p_no_fire_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |-> !fire);
endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
    parameter int RES_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic [RES_W-1:0]  res,
    input  logic [2:0]        fmt,
    output logic [DATA_W-1:0] dout
);
    localparam int HALF_W = DATA_W / 2;
    localparam int MSB    = RES_W - 1;

    logic [RES_W-1:0] sres;

    always_comb begin
        sres = {~res[MSB], res[MSB-1:0]};
        dout = '0;
        case (fmt)
            3'b001: dout[HALF_W-1:0] = {{(HALF_W - RES_W){sres[MSB]}}, sres};
            3'b010: dout[HALF_W-1 -: RES_W] = res;
            3'b011: dout[HALF_W-1 -: RES_W] = sres;
            3'b101: dout = {{(DATA_W - RES_W){sres[MSB]}}, sres};
            3'b110: dout[DATA_W-1 -: RES_W] = res;
            3'b111: dout[DATA_W-1 -: RES_W] = sres;
            default: dout[RES_W-1:0] = res;
        endcase
    end

    always_comb begin
        if (fmt == 3'b000 || fmt == 3'b100) begin
            p_uint_upper_zero_r7: assert (dout[DATA_W-1:RES_W] == '0)
                else $error("unsigned integer format has upper bits set");
        end
        if (fmt[2] == 1'b0) begin
            p_half_upper_zero_r7: assert (dout[DATA_W-1:HALF_W] == '0)
                else $error("16-bit format has upper half set");
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int DATA_W      = 32,
    parameter int SAMP_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              trig_pin,
    input  logic              trig_tmr,
    input  logic              trig_meas,
    output logic              conv_start,
    input  logic              conv_busy,
    input  logic              conv_valid,
    input  logic [RES_W-1:0]  conv_result,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic             en;
        logic             asam;
        logic             samp;
        logic             done;
        logic [2:0]       fmt;
        logic [2:0]       tsel;
        logic             conv;
        logic             start;
        logic [RES_W-1:0] res;
    } ctrl_state_t;

    ctrl_state_t q, d;
    logic busy, arm, sw_end, fire, completes;
    logic unused_wdata;

    assign unused_wdata = ^{reg_wdata[DATA_W-1:TSEL_LSB+3], reg_wdata[FMT_LSB+3]};

    assign busy   = q.conv | conv_busy;
    assign arm    = q.en & q.samp & ~busy;
    assign sw_end = reg_wr & ~reg_wdata[BIT_SAMP];

    adc_seq_trig #(.SAMP_CYCLES(SAMP_CYCLES)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .tsel   (q.tsel),
        .arm    (arm),
        .sw_end (sw_end),
        .pin    (trig_pin),
        .tmr    (trig_tmr),
        .meas   (trig_meas),
        .fire   (fire)
    );

    always_comb begin
        d         = q;
        d.start   = 1'b0;
        completes = q.conv & conv_valid;
        if (reg_wr) begin
            d.en   = reg_wdata[BIT_EN];
            d.asam = reg_wdata[BIT_ASAM];
            d.fmt  = reg_wdata[FMT_LSB +: 3];
            d.tsel = reg_wdata[TSEL_LSB +: 3];
            if (!reg_wdata[BIT_DONE]) d.done = 1'b0;
            if (reg_wdata[BIT_SAMP] && q.en && !q.conv) d.samp = 1'b1;
        end
        if (fire) begin
            d.samp  = 1'b0;
            d.done  = 1'b0;
            d.conv  = 1'b1;
            d.start = 1'b1;
        end else if (q.asam && q.en && !q.samp && !q.conv) begin
            d.samp = 1'b1;
        end
        if (completes) begin
            d.conv = 1'b0;
            d.done = 1'b1;
            d.res  = conv_result;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata                   = '0;
        reg_rdata[BIT_EN]           = q.en;
        reg_rdata[BIT_ASAM]         = q.asam;
        reg_rdata[BIT_SAMP]         = q.samp;
        reg_rdata[BIT_DONE]         = q.done;
        reg_rdata[FMT_LSB +: 3]     = q.fmt;
        reg_rdata[TSEL_LSB +: 3]    = q.tsel;
    end

    assign conv_start = q.start;

    adc_seq_fmt #(.RES_W(RES_W), .DATA_W(DATA_W)) u_fmt (
        .res  (q.res),
        .fmt  (q.fmt),
        .dout (dout)
    );

    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    p_start_clears_samp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !reg_rdata[BIT_SAMP]);
    p_start_clears_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !reg_rdata[BIT_DONE]);
    p_no_start_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[BIT_EN] |=> !conv_start);
    p_no_start_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tsel_reserved(reg_rdata[TSEL_LSB +: 3]) |=> !conv_start);
    p_done_write1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[BIT_DONE] && !reg_rdata[BIT_DONE] && !conv_valid)
        |=> !reg_rdata[BIT_DONE]);
    p_collision_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.conv && conv_valid) |=> reg_rdata[BIT_DONE]);
    p_auto_resample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reg_rdata[BIT_DONE]) && reg_rdata[BIT_ASAM] && reg_rdata[BIT_EN] && !reg_wr)
        |=> reg_rdata[BIT_SAMP]);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
    localparam int SAMP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        trig_pin = 1'b0, trig_tmr = 1'b0, trig_meas = 1'b0;
    logic        conv_start;
    logic        conv_busy = 1'b0, conv_valid = 1'b0;
    logic [9:0]  conv_result = '0;
    logic [31:0] dout;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl #(.SAMP_CYCLES(SAMP)) u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trig_pin(trig_pin), .trig_tmr(trig_tmr),
        .trig_meas(trig_meas), .conv_start(conv_start), .conv_busy(conv_busy),
        .conv_valid(conv_valid), .conv_result(conv_result), .dout(dout)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input bit en, input bit asam, input bit samp,
                                       input bit done, input logic [2:0] fmt,
                                       input logic [2:0] tsel);
        logic [31:0] w = '0;
        w[0] = en; w[1] = asam; w[2] = samp; w[3] = done;
        w[6:4] = fmt; w[10:8] = tsel;
        return w;
    endfunction

    function automatic logic [31:0] expect_fmt(input logic [9:0] r, input logic [2:0] f);
        int u = int'(r);
        int s = u - 512;
        logic [31:0] s32 = 32'(s);
        logic [31:0] s10 = 32'(u ^ 512);
        case (f)
            3'd1: return s32 & 32'h0000_FFFF;
            3'd2: return 32'(u) << 6;
            3'd3: return s10 << 6;
            3'd5: return s32;
            3'd6: return 32'(u) << 22;
            3'd7: return s10 << 22;
            default: return 32'(u);
        endcase
    endfunction

    task automatic wr(input logic [31:0] w);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = w;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic count_starts(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (conv_start) n++;
        end
    endtask

    task automatic wait_start(output bit ok);
        int n = 0;
        while (!conv_start && n < 60) begin @(negedge clk); n++; end
        ok = conv_start;
    endtask

    // converter model; optional done-clear write in the completion cycle
    task automatic finish_conv(input logic [9:0] r, input bit clr, input logic [31:0] clr_w);
        conv_busy = 1'b1;
        repeat (3) @(negedge clk);
        conv_valid = 1'b1; conv_result = r;
        if (clr) begin reg_wr = 1'b1; reg_wdata = clr_w; end
        @(negedge clk);
        conv_valid = 1'b0; conv_busy = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 1) trig_pin = 1'b1;
        if (which == 2) trig_tmr = 1'b1;
        if (which == 3) trig_meas = 1'b1;
        @(negedge clk);
        trig_pin = 1'b0; trig_tmr = 1'b0; trig_meas = 1'b0;
    endtask

    task automatic do_conv(input logic [2:0] tsel, input logic [2:0] fmt, input logic [9:0] r);
        bit ok;
        wr(cw(1, 0, 0, 1, fmt, tsel));
        wr(cw(1, 0, 1, 1, fmt, tsel));
        check("R3 sample set by write", 32'(reg_rdata[2]), 32'd1);
        case (tsel)
            3'd0: wr(cw(1, 0, 0, 1, fmt, tsel));
            3'd1: pulse(1);
            3'd2: pulse(2);
            3'd3: pulse(3);
            default: ;
        endcase
        wait_start(ok);
        check("R2 start issued for trigger", 32'(ok), 32'd1);
        check("R5 done and sample clear at start", 32'(reg_rdata[3:2]), 32'd0);
        finish_conv(r, 0, '0);
        check("R5 done set on completion", 32'(reg_rdata[3]), 32'd1);
        check("R7 formatted output", dout, expect_fmt(r, fmt));
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        bit ok;
        int n;
        logic [2:0] tsels [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7};
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        check("R1 reset control word", reg_rdata, 32'h0);
        check("R1 reset dout", dout, 32'h0);
        check("R1 reset conv_start", 32'(conv_start), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // field layout, unimplemented bits, done write 1 ignored; disabled
        wr(32'hFFFF_FFFE);
        check("R1 readback fields", reg_rdata, 32'h0000_0772);
        count_starts(10, n);
        check("R8 no activity while disabled", {reg_rdata[2], 31'(n)}, 32'd0);

        // directed conversion per trigger
        do_conv(3'd0, 3'd0, 10'h3FF);
        do_conv(3'd1, 3'd1, 10'h000);
        do_conv(3'd2, 3'd3, 10'h200);
        do_conv(3'd3, 3'd5, 10'h1FF);
        do_conv(3'd7, 3'd7, 10'h001);

        // R4 sample window length with internal counter
        wr(cw(1, 0, 0, 1, 3'd6, 3'd7));
        @(negedge clk); reg_wr = 1'b1; reg_wdata = cw(1, 0, 1, 1, 3'd6, 3'd7);
        @(negedge clk); reg_wr = 1'b0;
        n = 0;
        while (reg_rdata[2] && n < 20) begin n++; @(negedge clk); end
        check("R4 sample cycles", 32'(n), 32'(SAMP));
        check("R4 start after window", 32'(conv_start), 32'd1);
        // R8 sample write and trigger ignored while converting
        conv_busy = 1'b1;
        wr(cw(1, 0, 1, 0, 3'd6, 3'd2));
        check("R8 sample write ignored while busy", 32'(reg_rdata[2]), 32'd0);
        pulse(2);
        count_starts(4, n);
        check("R8 trigger ignored while busy", 32'(n), 32'd0);
        finish_conv(10'h2A5, 0, '0);
        check("R6 clear mid-conversion harmless", dout, expect_fmt(10'h2A5, 3'd6));
        check("R6 done after clear mid-conversion", 32'(reg_rdata[3]), 32'd1);

        // R6 done write semantics
        wr(cw(1, 0, 0, 1, 3'd0, 3'd2));
        check("R6 write 1 keeps done", 32'(reg_rdata[3]), 32'd1);
        wr(cw(1, 0, 0, 0, 3'd0, 3'd2));
        check("R6 write 0 clears done", 32'(reg_rdata[3]), 32'd0);
        wr(cw(1, 0, 0, 1, 3'd0, 3'd2));
        check("R6 write 1 does not set done", 32'(reg_rdata[3]), 32'd0);

        // R6 collision: clear and completion in the same cycle
        wr(cw(1, 0, 1, 0, 3'd2, 3'd2));
        pulse(2);
        wait_start(ok);
        finish_conv(10'h155, 1, cw(1, 0, 0, 0, 3'd2, 3'd2));
        check("R6 completion wins over clear", 32'(reg_rdata[3]), 32'd1);
        check("R6 collision result", dout, expect_fmt(10'h155, 3'd2));

        // R8 reserved select
        wr(cw(1, 0, 0, 1, 3'd0, 3'd5));
        wr(cw(1, 0, 1, 1, 3'd0, 3'd5));
        pulse(1); pulse(2); pulse(3);
        count_starts(8, n);
        check("R8 reserved select ignored", {reg_rdata[2], 31'(n)}, 32'h8000_0000);
        // R8 disabled
        wr(cw(0, 0, 0, 1, 3'd0, 3'd2));
        pulse(2);
        count_starts(4, n);
        check("R8 disabled trigger ignored", {reg_rdata[2], 31'(n)}, 32'h8000_0000);
        // R3 software end of sampling
        wr(cw(1, 0, 0, 1, 3'd0, 3'd0));
        wr(cw(1, 0, 0, 1, 3'd0, 3'd0));
        wait_start(ok);
        check("R3 software write starts conversion", 32'(ok), 32'd1);
        finish_conv(10'h0F0, 0, '0);

        // R9 auto-sample restart
        wr(cw(1, 1, 0, 1, 3'd4, 3'd7));
        wait_start(ok);
        finish_conv(10'h321, 0, '0);
        check("R9 sample low when done rises", 32'(reg_rdata[3:2]), 32'd2);
        @(negedge clk);
        check("R9 sample high next cycle", 32'(reg_rdata[2]), 32'd1);
        wr(cw(1, 0, 0, 1, 3'd4, 3'd7));
        wait_start(ok);
        finish_conv(10'h011, 0, '0);

        // constrained random conversions
        for (int i = 0; i < 40; i++) begin
            do_conv(tsels[$urandom_range(0, 4)], 3'($urandom_range(0, 7)),
                    10'($urandom_range(0, 1023)));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule